// File: doc/BRIEF.md
# Data-Stall Hung Timeout Monitor

This block watches data channels for inactivity. Every channel has an activity strobe that pulses whenever a byte moves, an enable bit, an 8-bit timeout threshold and a 3-bit prescale shift. While the channel is enabled and idle, a prescaler divides the clock into ticks. Its period is a base count shifted right by the shift field. Each tick advances a saturating timeout counter. When that counter passes the threshold, the channel raises a sticky raw hung flag.

The default build has two independent channels: channel 0 watches the receive direction and channel 1 watches the transmit direction. Software clears a flag with a one-cycle write-one-to-clear pulse on the matching clear input. Interrupt masking and status aggregation happen outside this block.

Top module: `stall_watch`

## Requirements
- R1: After reset every hung output is 0 and every channel's tick and timeout counts are 0.
- R2: While a channel is enabled and its activity strobe is low, its tick period is L = max(1, BASE_COUNT >> shift) clock cycles. The shift field of channel c sits at shift_i[3c+2:3c].
- R3: A channel whose enable is low never raises its hung output.
- R4: Activity sampled on edge k starts a stall. The hung output then rises on edge k + (thr+1)*L + 1, where the threshold of channel c is thr_i[8c+7:8c]. With thr = 255 the flag never rises.
- R5: The timeout count saturates at 255 and does not wrap. After a long stall at thr = 255, lowering thr below 255 raises the flag one edge later.
- R6: An activity strobe clears that channel's tick and timeout counts, so a full new window starts.
- R7: A raised hung output stays high until a clear pulse on clr_i[c] is sampled and is low after that edge. If the flag is raised on the same edge as a clear, the raise wins. A clear does not restart the counts.
- R8: The flag is raised at most once per stall. After a clear, it stays low until activity or a disable starts a new stall.
- R9: Driving enable low for one edge resets both counts, so the next stall needs a full window.
- R10: The channels are independent. One channel's inputs never change another channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_i | input | NUM_CH | Per-channel byte activity strobe |
| en_i | input | NUM_CH | Per-channel monitor enable |
| thr_i | input | NUM_CH*THR_W | Per-channel timeout threshold, channel c at [8c+7:8c] |
| shift_i | input | NUM_CH*SHIFT_W | Per-channel prescale shift, channel c at [3c+2:3c] |
| clr_i | input | NUM_CH | Per-channel write-one-to-clear pulse for the hung flag |
| hung_o | output | NUM_CH | Per-channel sticky raw hung flag |

## Verification
The bench checks the exact edge on which the flag rises against the window formula, with a shift value that divides and with shift 0. An off-by-one in either the tick wrap or the threshold compare would move that edge by a tick or by a cycle. Saturation is probed by lowering the threshold after a long stall: a counter that wraps would have passed back to a small value and would miss the immediate raise. Clear-then-wait catches a design that re-fires within a single stall. A one-cycle disable in mid-stall catches counts that survive the disable. A long randomized run also races clear against raise and compares against a per-cycle bench model.

// File: rtl/stall_watch_pkg.sv
package stall_watch_pkg;

    localparam int unsigned RX_CH = 0;
    localparam int unsigned TX_CH = 1;

    // Prescaler period for a given shift, never below one cycle.
    function automatic int unsigned tick_limit(int unsigned base, int unsigned sh);
        int unsigned r;
        r = base >> sh;
        return (r == 0) ? 1 : r;
    endfunction

endpackage

// File: rtl/sw_tick_div.sv
module sw_tick_div #(
    parameter int unsigned BASE_COUNT = 8000,
    parameter int unsigned SHIFT_W    = 3,
    parameter int unsigned CNT_W      = $clog2(BASE_COUNT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [SHIFT_W-1:0] shift,
    output logic               wrap
);
    import stall_watch_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] tick;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim  = CNT_W'(tick_limit(BASE_COUNT, 32'(shift)));
        wrap = run && (st_q.tick >= lim - 1'b1);
        st_d = st_q;
        if (!run || wrap) begin
            st_d.tick = '0;
        end else begin
            st_d.tick = st_q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_WRAP_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (st_q.tick == '0)); // R2
    AST_TICK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tick <= CNT_W'(BASE_COUNT - 1)); // R2
    AST_IDLE_CLEARS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.tick == '0)); // R6

endmodule

// File: rtl/sw_stall_cnt.sv
module sw_stall_cnt #(
    parameter int unsigned THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             act,
    input  logic             wrap,
    input  logic [THR_W-1:0] thr,
    input  logic             clr,
    output logic             hung
);
    localparam logic [THR_W-1:0] TO_MAX = '1;

    typedef struct packed {
        logic [THR_W-1:0] to;
        logic             fired;
        logic             hung;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    set_now;

    always_comb begin
        st_d    = st_q;
        set_now = en && !act && !st_q.fired && (st_q.to > thr);
        st_d.hung = (st_q.hung && !clr) || set_now;
        if (!en || act) begin
            st_d.to    = '0;
            st_d.fired = 1'b0;
        end else begin
            st_d.fired = st_q.fired || set_now;
            if (wrap && (st_q.to != TO_MAX)) begin
                st_d.to = st_q.to + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hung = st_q.hung;

    AST_STICKY_HUNG: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hung && !clr) |=> st_q.hung); // R7
    AST_DISABLED_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !st_q.hung) |=> !st_q.hung); // R3
    AST_RISE_NEEDS_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.hung) |-> ($past(st_q.to) > $past(thr))); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !act && wrap && (st_q.to == TO_MAX)) |=> (st_q.to == TO_MAX)); // R5
    AST_ACT_CLEARS_TO: assert property (@(posedge clk) disable iff (!rst_n)
        (en && act) |=> (st_q.to == '0)); // R6
    AST_ONCE_PER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fired && en && !act) |=> !$rose(st_q.hung)); // R8
    AST_DISABLE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ((st_q.to == '0) && !st_q.fired)); // R9

endmodule

// File: rtl/sw_channel.sv
module sw_channel #(
    parameter int unsigned BASE_COUNT = 8000,
    parameter int unsigned THR_W      = 8,
    parameter int unsigned SHIFT_W    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               act,
    input  logic               en,
    input  logic [THR_W-1:0]   thr,
    input  logic [SHIFT_W-1:0] shift,
    input  logic               clr,
    output logic               hung
);
    logic run;
    logic wrap;

    assign run = en && !act;

    sw_tick_div #(
        .BASE_COUNT (BASE_COUNT),
        .SHIFT_W    (SHIFT_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .shift (shift),
        .wrap  (wrap)
    );

    sw_stall_cnt #(
        .THR_W (THR_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .act   (act),
        .wrap  (wrap),
        .thr   (thr),
        .clr   (clr),
        .hung  (hung)
    );

    AST_WRAP_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> (en && !act)); // R6

endmodule

// File: rtl/stall_watch.sv
module stall_watch #(
    parameter int unsigned NUM_CH     = 2,
    parameter int unsigned BASE_COUNT = 8000,
    parameter int unsigned THR_W      = 8,
    parameter int unsigned SHIFT_W    = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CH-1:0]           act_i,
    input  logic [NUM_CH-1:0]           en_i,
    input  logic [NUM_CH*THR_W-1:0]     thr_i,
    input  logic [NUM_CH*SHIFT_W-1:0]   shift_i,
    input  logic [NUM_CH-1:0]           clr_i,
    output logic [NUM_CH-1:0]           hung_o
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        sw_channel #(
            .BASE_COUNT (BASE_COUNT),
            .THR_W      (THR_W),
            .SHIFT_W    (SHIFT_W)
        ) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .act   (act_i[c]),
            .en    (en_i[c]),
            .thr   (thr_i[c*THR_W +: THR_W]),
            .shift (shift_i[c*SHIFT_W +: SHIFT_W]),
            .clr   (clr_i[c]),
            .hung  (hung_o[c])
        );
    end

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> (hung_o == '0)); // R1

endmodule

// File: tb/stall_watch_bench.sv
module stall_watch_bench;
    localparam int BASE = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] act = '0;
    logic [1:0] en = '0;
    logic [1:0] clr = '0;
    logic [15:0] thr = '0;
    logic [5:0]  shift = '0;
    logic [1:0]  hung;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_tick[2];
    int m_to[2];
    bit m_fired[2];
    bit m_hung[2];

    always #2 clk = ~clk;

    stall_watch #(.NUM_CH(2), .BASE_COUNT(BASE)) u_stall_watch (
        .clk(clk), .rst_n(rst_n), .act_i(act), .en_i(en), .thr_i(thr),
        .shift_i(shift), .clr_i(clr), .hung_o(hung)
    );

    function automatic int lim_of(int sh);
        int r;
        r = BASE >> sh;
        return (r == 0) ? 1 : r;
    endfunction

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // Per-cycle reference model built from the requirements.
    always @(posedge clk) begin
        int t;
        int l;
        bit run;
        bit set;
        for (int c = 0; c < 2; c++) begin
            if (!rst_n) begin
                m_tick[c] = 0; m_to[c] = 0; m_fired[c] = 0; m_hung[c] = 0;
            end else begin
                t   = int'(thr[c*8 +: 8]);
                l   = lim_of(int'(shift[c*3 +: 3]));
                run = en[c] && !act[c];
                set = run && !m_fired[c] && (m_to[c] > t);
                m_hung[c] = (m_hung[c] && !clr[c]) || set;
                if (!run) begin
                    m_tick[c] = 0; m_to[c] = 0; m_fired[c] = 0;
                end else begin
                    if (set) m_fired[c] = 1;
                    if (m_tick[c] >= l - 1) begin
                        m_tick[c] = 0;
                        if (m_to[c] < 255) m_to[c] = m_to[c] + 1;
                    end else begin
                        m_tick[c] = m_tick[c] + 1;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int c = 0; c < 2; c++) begin
                check($sformatf("R10 model ch%0d", c), int'(hung[c]), int'(m_hung[c]));
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_act(int c);
        act[c] = 1'b1; cyc(1); act[c] = 1'b0;
    endtask

    task automatic pulse_clr(int c);
        clr[c] = 1'b1; cyc(1); clr[c] = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        check("R1 reset hung", int'(hung), 0);

        // R3: disabled channels at a tiny threshold never flag
        thr = {8'd0, 8'd0}; shift = {3'd7, 3'd7};
        cyc(60);
        check("R3 disabled ch0", int'(hung[0]), 0);
        check("R3 disabled ch1", int'(hung[1]), 0);

        // R4 / R2: ch0 thr=3, shift=5 -> L=6; ch1 held active (R10)
        thr = {8'd0, 8'd3}; shift = {3'd7, 3'd5};
        en = 2'b11; act[1] = 1'b1;
        pulse_act(0);
        cyc(24);
        check("R4 window edge-1", int'(hung[0]), 0);
        cyc(1);
        check("R4 window edge", int'(hung[0]), 1);
        check("R10 busy ch1 quiet", int'(hung[1]), 0);

        // R7 sticky, then clear
        cyc(50);
        check("R7 sticky", int'(hung[0]), 1);
        pulse_clr(0);
        check("R7 cleared", int'(hung[0]), 0);
        // R8 once per stall
        cyc(100);
        check("R8 no refire", int'(hung[0]), 0);
        // R6 activity restarts window
        pulse_act(0);
        cyc(24);
        check("R6 restart edge-1", int'(hung[0]), 0);
        cyc(1);
        check("R6 restart edge", int'(hung[0]), 1);

        // R9: one-cycle disable in mid-stall restarts window
        pulse_clr(0);
        pulse_act(0);
        cyc(20);
        en[0] = 1'b0; cyc(1); en[0] = 1'b1;
        cyc(24);
        check("R9 full window edge-1", int'(hung[0]), 0);
        cyc(1);
        check("R9 full window edge", int'(hung[0]), 1);

        // R2: shift 0 -> L=BASE, thr 0
        pulse_clr(0);
        thr[7:0] = 8'd0; shift[2:0] = 3'd0;
        pulse_act(0);
        cyc(BASE);
        check("R2 shift0 edge-1", int'(hung[0]), 0);
        cyc(1);
        check("R2 shift0 edge", int'(hung[0]), 1);

        // R5: saturation, thr=255 never fires, then lower thr
        pulse_clr(0);
        thr[7:0] = 8'd255; shift[2:0] = 3'd7;
        pulse_act(0);
        cyc(300);
        check("R4 thr255 never", int'(hung[0]), 0);
        thr[7:0] = 8'd200;
        cyc(1);
        check("R5 saturated count", int'(hung[0]), 1);

        // Random phase, compared each cycle against the model
        act = '0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            for (int c = 0; c < 2; c++) begin
                act[c] = ($urandom % 40) == 0;
                clr[c] = ($urandom % 25) == 0;
                if (($urandom % 300) == 0) en[c] = ~en[c];
                if (($urandom % 200) == 0) begin
                    thr[c*8 +: 8]   = 8'($urandom % 6);
                    shift[c*3 +: 3] = 3'(4 + ($urandom % 4));
                end
            end
        end
        cyc(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule